// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two unsigned operands and a carry-in with no clock and no state. The default width is 16 bits. The operand width is split into 4-bit slices. Each slice forms a per-bit generate (both inputs 1) and a per-bit propagate (inputs differ). From these terms it produces every internal carry as one flat sum of products over the slice's own carry-in, and then forms its sum bits.

Each slice also reports a slice-wide propagate and a slice-wide generate. A second lookahead stage combines these pairs with the external carry-in. In the same flat sum-of-products form, it produces the carry into every slice and the final carry-out. No carry is chained bit to bit or slice to slice. The slice propagate and generate vectors are brought to the ports, so a wider adder can stack a further lookahead level on top.

Top module: `hcla_adder`

## Requirements
- R1: For every input combination, {carry_out, sum_o} equals opnd_a + opnd_b + carry_in as a 17-bit unsigned value.
- R2: grp_prop[k] is 1 exactly when every bit i of slice k (bits 4k+3 down to 4k) has opnd_a[i] XOR opnd_b[i] = 1.
- R3: grp_gen[k] is 1 exactly when the 4-bit slice k of opnd_a plus the same slice of opnd_b, added with no carry-in, exceeds 15.
- R4: An all-ones opnd_a plus a zero opnd_b with carry_in = 1 gives sum_o = 0 and carry_out = 1, so the carry crosses every slice.
- R5: A zero opnd_a plus a zero opnd_b gives sum_o equal to carry_in and carry_out = 0.
- R6: No slice ever asserts grp_prop[k] and grp_gen[k] together.
- R7: When every grp_prop bit is 1, carry_out equals carry_in and sum_o equals the bitwise inverse of carry_in replicated across all bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 16 | First addend |
| opnd_b | input | 16 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |
| grp_prop | output | 4 | Slice-wide propagate, one bit per 4-bit slice |
| grp_gen | output | 4 | Slice-wide generate, one bit per 4-bit slice |

## Verification
The checker re-evaluates the arithmetic result, the slice propagate and generate definitions, the exclusion between them, and the pass-through of the carry whenever an input changes. These checks cover R1, R2, R3, R6 and R7 for any stimulus. Only the bench's directed scenarios show that the extreme operand patterns actually occur and give the expected values. These patterns are the full-length carry chain, zero operands, and alternating bit patterns. Exhaustive sweeps of the lowest slice and random vectors fill in the rest.

// File: rtl/hcla_pkg.sv
package hcla_pkg;
  localparam int unsigned SLICE_W = 4;

  function automatic int unsigned slice_count(input int unsigned width);
    return width / SLICE_W;
  endfunction
endpackage

// File: rtl/hcla_bit_pg.sv
module hcla_bit_pg #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] gen_o,
  output logic [W-1:0] prop_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gen_o[i]  = a_i[i] & b_i[i];
    assign prop_o[i] = a_i[i] ^ b_i[i];
  end
endmodule

// File: rtl/hcla_lookahead.sv
// Flat sum-of-products lookahead: every carry is an OR of AND terms over
// generate/propagate inputs and the incoming carry; nothing is chained.
module hcla_lookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin_i,
  output logic [N:1]   carry_o,
  output logic         blk_prop_o,
  output logic         blk_gen_o
);
  always_comb begin
    for (int k = 1; k <= N; k++) begin
      logic acc;
      logic tail;
      tail = cin_i;
      for (int m = 0; m < k; m++) tail = tail & prop_i[m];
      acc = tail;
      for (int j = 0; j < k; j++) begin
        logic term;
        term = gen_i[j];
        for (int m = j + 1; m < k; m++) term = term & prop_i[m];
        acc = acc | term;
      end
      carry_o[k] = acc;
    end
  end

  always_comb begin
    blk_prop_o = &prop_i;
    blk_gen_o  = 1'b0;
    for (int j = 0; j < N; j++) begin
      logic term;
      term = gen_i[j];
      for (int m = j + 1; m < N; m++) term = term & prop_i[m];
      blk_gen_o = blk_gen_o | term;
    end
  end
endmodule

// File: rtl/hcla_slice.sv
module hcla_slice #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         sp_o,
  output logic         sg_o
);
  logic [W-1:0] bit_g;
  logic [W-1:0] bit_p;
  logic [W:1]   inner_c;
  logic [W-1:0] c_at;

  hcla_bit_pg #(.W(W)) u_pg (
    .a_i    (a_i),
    .b_i    (b_i),
    .gen_o  (bit_g),
    .prop_o (bit_p)
  );

  hcla_lookahead #(.N(W)) u_la (
    .gen_i      (bit_g),
    .prop_i     (bit_p),
    .cin_i      (cin_i),
    .carry_o    (inner_c),
    .blk_prop_o (sp_o),
    .blk_gen_o  (sg_o)
  );

  assign c_at = {inner_c[W-1:1], cin_i};
  assign sum_o = bit_p ^ c_at;
endmodule

// File: rtl/hcla_adder.sv
module hcla_adder #(
  parameter int unsigned WIDTH = 16,
  localparam int unsigned NSL  = hcla_pkg::slice_count(WIDTH),
  localparam int unsigned SW   = hcla_pkg::SLICE_W
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_out,
  output logic [NSL-1:0]   grp_prop,
  output logic [NSL-1:0]   grp_gen
);
  logic [NSL:1]   top_c;
  logic [NSL-1:0] slice_cin;
  logic           top_p;
  logic           top_g;

  assign slice_cin = {top_c[NSL-1:1], carry_in};

  for (genvar k = 0; k < NSL; k++) begin : g_slice
    hcla_slice #(.W(SW)) u_slice (
      .a_i   (opnd_a[k*SW +: SW]),
      .b_i   (opnd_b[k*SW +: SW]),
      .cin_i (slice_cin[k]),
      .sum_o (sum_o[k*SW +: SW]),
      .sp_o  (grp_prop[k]),
      .sg_o  (grp_gen[k])
    );
  end

  hcla_lookahead #(.N(NSL)) u_lvl2 (
    .gen_i      (grp_gen),
    .prop_i     (grp_prop),
    .cin_i      (carry_in),
    .carry_o    (top_c),
    .blk_prop_o (top_p),
    .blk_gen_o  (top_g)
  );

  assign carry_out = top_c[NSL];

  logic unused_top;
  assign unused_top = top_p ^ top_g;
endmodule

// File: rtl/hcla_adder_chk.sv
module hcla_adder_chk #(
  parameter int unsigned WIDTH = 16,
  localparam int unsigned NSL  = WIDTH / 4
) (
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic             carry_in,
  input logic [WIDTH-1:0] sum_o,
  input logic             carry_out,
  input logic [NSL-1:0]   grp_prop,
  input logic [NSL-1:0]   grp_gen
);
  initial begin
    assert_width_mult4_R1: assert (WIDTH % 4 == 0 && WIDTH > 0)
      else $error("WIDTH must be a positive multiple of 4");
  end

  always_comb begin
    logic [WIDTH:0] ref_total;
    ref_total = {1'b0, opnd_a} + {1'b0, opnd_b} + {{WIDTH{1'b0}}, carry_in};
    assert_sum_R1: assert ({carry_out, sum_o} == ref_total)
      else $error("R1 sum mismatch");
    for (int k = 0; k < NSL; k++) begin
      logic [4:0] part;
      part = {1'b0, opnd_a[k*4 +: 4]} + {1'b0, opnd_b[k*4 +: 4]};
      assert_prop_R2: assert (grp_prop[k] == ((opnd_a[k*4 +: 4] ^ opnd_b[k*4 +: 4]) == 4'hF))
        else $error("R2 slice propagate wrong");
      assert_gen_R3: assert (grp_gen[k] == part[4])
        else $error("R3 slice generate wrong");
      assert_excl_R6: assert (!(grp_prop[k] && grp_gen[k]))
        else $error("R6 propagate and generate both set");
    end
    if (&grp_prop) begin
      assert_pass_R7: assert (carry_out == carry_in && sum_o == {WIDTH{~carry_in}})
        else $error("R7 carry pass-through wrong");
    end
  end
endmodule

bind hcla_adder hcla_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .carry_in  (carry_in),
  .sum_o     (sum_o),
  .carry_out (carry_out),
  .grp_prop  (grp_prop),
  .grp_gen   (grp_gen)
);

// File: tb/test_hcla_adder.sv
`timescale 1ns/1ps
module test_hcla_adder;
  localparam int W  = 16;
  localparam int NS = W / 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [W-1:0]  a, b, s;
  logic          ci, co;
  logic [NS-1:0] gp, gg;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  hcla_adder #(.WIDTH(W)) i_hcla_adder (
    .opnd_a(a), .opnd_b(b), .carry_in(ci),
    .sum_o(s), .carry_out(co), .grp_prop(gp), .grp_gen(gg)
  );

  task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
    @(posedge clk);
    a = va; b = vb; ci = vc;
    @(negedge clk);
  endtask

  // Compares the current outputs with values computed from the requirements.
  task automatic check_all(input string tag);
    logic [W:0]    exp_tot;
    logic [NS-1:0] exp_p, exp_g;
    exp_tot = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    for (int k = 0; k < NS; k++) begin
      logic [4:0] part;
      part = {1'b0, a[k*4 +: 4]} + {1'b0, b[k*4 +: 4]};
      exp_g[k] = part[4];
      exp_p[k] = ((a[k*4 +: 4] ^ b[k*4 +: 4]) == 4'hF);
    end
    n_chk++;
    if ({co, s} !== exp_tot) begin
      n_bad++;
      $display("FAIL R1 %s: got %h expected %h", tag, {co, s}, exp_tot);
    end
    n_chk++;
    if (gp !== exp_p) begin
      n_bad++;
      $display("FAIL R2 %s: got %b expected %b", tag, gp, exp_p);
    end
    n_chk++;
    if (gg !== exp_g) begin
      n_bad++;
      $display("FAIL R3 %s: got %b expected %b", tag, gg, exp_g);
    end
    n_chk++;
    if ((gp & gg) !== '0) begin
      n_bad++;
      $display("FAIL R6 %s: got overlap %b expected %b", tag, gp & gg, {NS{1'b0}});
    end
  endtask

  task automatic check_val(input string req, input logic [W:0] got, input logic [W:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic t_idle;
    apply('0, '0, 1'b0);
    check_val("R5 initial zero", {co, s}, '0);
    check_all("idle");
  endtask

  task automatic t_zero;
    apply('0, '0, 1'b0);
    check_val("R5 zero plus zero", {co, s}, 17'h0);
    apply('0, '0, 1'b1);
    check_val("R5 zero plus zero carry", {co, s}, 17'h1);
    check_all("zero");
  endtask

  task automatic t_full_chain;
    apply('1, '0, 1'b1);
    check_val("R4 all-ones plus carry", {co, s}, 17'h1_0000);
    check_val("R7 pass-through carry=1", {co, s}, {ci, {W{~ci}}});
    check_all("chain");
    apply('1, '0, 1'b0);
    check_val("R7 pass-through carry=0", {co, s}, {1'b0, {W{1'b1}}});
    apply(16'h5555, 16'hAAAA, 1'b1);
    check_val("R7 alt prop carry=1", {co, s}, 17'h1_0000);
    apply('1, '1, 1'b1);
    check_val("R1 all-ones plus all-ones", {co, s}, 17'h1_FFFF);
    check_all("ones");
  endtask

  task automatic t_alternating;
    apply(16'hAAAA, 16'hAAAA, 1'b0);
    check_val("R1 alt A+A", {co, s}, 17'h1_5554);
    check_all("altA");
    apply(16'h5555, 16'h5555, 1'b1);
    check_val("R1 alt 5+5+1", {co, s}, 17'h0_AAAB);
    check_all("alt5");
    apply(16'hF0F0, 16'h0F0F, 1'b1);
    check_all("nibble");
    apply(16'h00FF, 16'h0001, 1'b0);
    check_val("R1 byte carry", {co, s}, 17'h0_0100);
  endtask

  task automatic t_low_slice_sweep;
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        for (int c = 0; c < 2; c++) begin
          apply({12'hFFF, 4'(x)}, {12'h000, 4'(y)}, 1'(c));
          check_all("sweep");
        end
  endtask

  task automatic t_random;
    for (int i = 0; i < 2000; i++) begin
      apply(16'($urandom), 16'($urandom), 1'($urandom));
      check_all("random");
    end
  endtask

  initial begin
    a = '0; b = '0; ci = 1'b0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_idle();
    t_zero();
    t_full_chain();
    t_alternating();
    t_low_slice_sweep();
    t_random();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule